// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps wall-clock time as one wide binary counter advanced by a 32.768 kHz tick strobe. The counter is split into a whole-seconds word and a sub-second fraction word. A seconds-only alarm register sits beside it. Each time the fraction wraps, the alarm register is compared against the new seconds value. A match latches an alarm flag, and that flag drives an interrupt when the interrupt enable is on.

Software reaches the block through register-style strobes that share one data word: load seconds, load fraction, load alarm, set or clear control bits, and write-one-to-clear status flags. Counting stops on any of four conditions: the enable is off, the non-valid flag is set, the counter has overflowed, or the tamper monitor drives its stop input. After a power-up or an overflow the counter is frozen. It resumes only after the blocking flag is cleared, the enable is on, and a fresh seconds value has been loaded.

Top module: `sec_alarm_counter`

## Requirements
- R1: After reset the seconds and fraction are zero, the alarm register is all ones, both control bits are 0, the non-valid flag is 1, the other flags are 0 and the interrupt is low.
- R2: While running, each cycle with `tick_i` high adds one to the fraction. When the fraction is all ones, the tick clears it and adds one to the seconds. All updates show one cycle after the input.
- R3: Control bit 0 is the count enable. While it is 0, ticks are ignored. A change to it affects ticks from the following cycle.
- R4: Flag bit 0 is non-valid. While it is set, ticks are ignored. After it is cleared, counting stays frozen until a seconds load. A seconds load made while the flag is still set does not release the counter.
- R5: A tick taken when both seconds and fraction are all ones wraps both to zero, sets overflow flag bit 1 and stops counting. Restart needs that flag cleared and a new seconds load.
- R6: While `fail_stop_i` is high, ticks are ignored and seconds and fraction loads have no effect.
- R7: A seconds load writes the whole data word to the seconds and keeps the fraction. A fraction load writes the low fraction-width bits and keeps the seconds. A load in the same cycle as a tick wins, and the tick is dropped.
- R8: When the fraction wraps and the new seconds equal the alarm register, alarm flag bit 2 is set. An all-ones alarm register never matches.
- R9: `irq_o` is high exactly when the alarm flag is set and control bit 1 (interrupt enable) is set.
- R10: A one in `flag_clr_i` clears the flag at the same position. A flag that is set and cleared in the same cycle stays set. A control bit that is both set and cleared in the same cycle ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32.768 kHz count strobe, one cycle wide |
| sec_wr_i | input | 1 | Load seconds from `wdata_i` |
| frac_wr_i | input | 1 | Load fraction from the low bits of `wdata_i` |
| alarm_wr_i | input | 1 | Load alarm seconds from `wdata_i` |
| wdata_i | input | SEC_W | Shared write data |
| ctl_set_i | input | 2 | Set control bits (0 enable, 1 interrupt enable) |
| ctl_clr_i | input | 2 | Clear control bits |
| flag_clr_i | input | 3 | Write-one-to-clear for flags (0 non-valid, 1 overflow, 2 alarm) |
| fail_stop_i | input | 1 | Stop request from the tamper monitor |
| sec_o | output | SEC_W | Live seconds count |
| frac_o | output | FRAC_W | Live fraction count |
| alarm_o | output | SEC_W | Alarm seconds register |
| ctl_o | output | 2 | Control bits |
| flags_o | output | 3 | Status flags |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with an 8-bit seconds word and a 3-bit fraction. With these widths a fraction wrap takes eight ticks, and the full-counter overflow is reached from a single preload. The alarm compare, the overflow stop and its release, and the all-ones alarm value can all be exercised with exact expected values in a few dozen cycles.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int CTL_W   = 2;
    localparam int CTL_EN  = 0;
    localparam int CTL_IE  = 1;
    localparam int FLG_W   = 3;
    localparam int FLG_NV  = 0;
    localparam int FLG_OVF = 1;
    localparam int FLG_ALM = 2;
endpackage

// File: rtl/sc_count.sv
module sc_count #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              sec_ld_i,
    input  logic              frac_ld_i,
    input  logic [SEC_W-1:0]  wdata_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              roll_o,
    output logic              wrap_o,
    output logic [SEC_W-1:0]  next_sec_o
);
    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [FRAC_W-1:0] frac;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic step, frac_full, sec_full;

    always_comb begin
        cnt_d      = cnt_q;
        step       = tick_i && run_i && !sec_ld_i && !frac_ld_i;
        frac_full  = &cnt_q.frac;
        sec_full   = &cnt_q.sec;
        next_sec_o = cnt_q.sec + 1'b1;
        if (step) begin
            if (frac_full) begin
                cnt_d.frac = '0;
                cnt_d.sec  = next_sec_o;
            end else begin
                cnt_d.frac = cnt_q.frac + 1'b1;
            end
        end
        if (sec_ld_i)  cnt_d.sec  = wdata_i;
        if (frac_ld_i) cnt_d.frac = wdata_i[FRAC_W-1:0];
        roll_o = step && frac_full;
        wrap_o = roll_o && sec_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sec_o  = cnt_q.sec;
    assign frac_o = cnt_q.frac;
endmodule

// File: rtl/sc_alarm.sv
module sc_alarm #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alarm_wr_i,
    input  logic [SEC_W-1:0] wdata_i,
    input  logic             roll_i,
    input  logic [SEC_W-1:0] next_sec_i,
    output logic [SEC_W-1:0] alarm_o,
    output logic             hit_o
);
    localparam logic [SEC_W-1:0] NO_ALARM = {SEC_W{1'b1}};

    logic [SEC_W-1:0] alarm_d, alarm_q;

    always_comb begin
        alarm_d = alarm_wr_i ? wdata_i : alarm_q;
        hit_o   = roll_i && (alarm_q != NO_ALARM) && (next_sec_i == alarm_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alarm_q <= NO_ALARM;
        else        alarm_q <= alarm_d;
    end

    assign alarm_o = alarm_q;
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl_set_i,
    input  logic [CTL_W-1:0] ctl_clr_i,
    input  logic [FLG_W-1:0] flag_clr_i,
    input  logic             hit_i,
    input  logic             wrap_i,
    input  logic             sec_ld_i,
    input  logic             fail_stop_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [FLG_W-1:0] flags_o,
    output logic             run_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [FLG_W-1:0] flg;
        logic             need_seed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ctl = (st_q.ctl & ~ctl_clr_i) | ctl_set_i;
        st_d.flg = st_q.flg & ~flag_clr_i;
        if (wrap_i) st_d.flg[FLG_OVF] = 1'b1;
        if (hit_i)  st_d.flg[FLG_ALM] = 1'b1;
        if (wrap_i)
            st_d.need_seed = 1'b1;
        else if (sec_ld_i && !st_q.flg[FLG_NV])
            st_d.need_seed = 1'b0;
        run_o = st_q.ctl[CTL_EN] && !st_q.flg[FLG_NV] && !st_q.flg[FLG_OVF]
                && !st_q.need_seed && !fail_stop_i;
        irq_o = st_q.flg[FLG_ALM] && st_q.ctl[CTL_IE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl          <= '0;
            st_q.flg          <= '0;
            st_q.flg[FLG_NV]  <= 1'b1;
            st_q.need_seed    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o   = st_q.ctl;
    assign flags_o = st_q.flg;
endmodule

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter
    import sc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              sec_wr_i,
    input  logic              frac_wr_i,
    input  logic              alarm_wr_i,
    input  logic [SEC_W-1:0]  wdata_i,
    input  logic [1:0]        ctl_set_i,
    input  logic [1:0]        ctl_clr_i,
    input  logic [2:0]        flag_clr_i,
    input  logic              fail_stop_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [SEC_W-1:0]  alarm_o,
    output logic [1:0]        ctl_o,
    output logic [2:0]        flags_o,
    output logic              irq_o
);
    logic             run, roll, wrap, hit;
    logic             sec_ld, frac_ld;
    logic [SEC_W-1:0] next_sec;

    assign sec_ld  = sec_wr_i  && !fail_stop_i;
    assign frac_ld = frac_wr_i && !fail_stop_i;

    sc_count #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
        .sec_ld_i(sec_ld), .frac_ld_i(frac_ld), .wdata_i(wdata_i),
        .sec_o(sec_o), .frac_o(frac_o), .roll_o(roll), .wrap_o(wrap),
        .next_sec_o(next_sec)
    );

    sc_alarm #(.SEC_W(SEC_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .alarm_wr_i(alarm_wr_i), .wdata_i(wdata_i),
        .roll_i(roll), .next_sec_i(next_sec), .alarm_o(alarm_o), .hit_o(hit)
    );

    sc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_set_i(ctl_set_i), .ctl_clr_i(ctl_clr_i),
        .flag_clr_i(flag_clr_i), .hit_i(hit), .wrap_i(wrap), .sec_ld_i(sec_ld),
        .fail_stop_i(fail_stop_i), .ctl_o(ctl_o), .flags_o(flags_o),
        .run_o(run), .irq_o(irq_o)
    );
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              sec_wr_i,
    input logic              frac_wr_i,
    input logic              fail_stop_i,
    input logic              run,
    input logic [SEC_W-1:0]  sec_o,
    input logic [FRAC_W-1:0] frac_o,
    input logic [SEC_W-1:0]  alarm_o,
    input logic [1:0]        ctl_o,
    input logic [2:0]        flags_o,
    input logic              irq_o
);
    assert_disabled_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_o[0] && !sec_wr_i && !frac_wr_i) |=> ($stable(sec_o) && $stable(frac_o)));

    assert_nonvalid_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[0] && !sec_wr_i && !frac_wr_i) |=> ($stable(sec_o) && $stable(frac_o)));

    assert_overflow_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_i && !sec_wr_i && !frac_wr_i && (&sec_o) && (&frac_o))
        |=> (flags_o[1] && sec_o == '0 && frac_o == '0));

    assert_fail_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_stop_i |=> ($stable(sec_o) && $stable(frac_o)));

    assert_no_alarm_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o == {SEC_W{1'b1}}) |=> !$rose(flags_o[2]));

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (ctl_o[1] && flags_o[2]));
endmodule

bind sec_alarm_counter sc_checker #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sec_wr_i(sec_wr_i),
    .frac_wr_i(frac_wr_i), .fail_stop_i(fail_stop_i), .run(run),
    .sec_o(sec_o), .frac_o(frac_o), .alarm_o(alarm_o), .ctl_o(ctl_o),
    .flags_o(flags_o), .irq_o(irq_o)
);

// File: tb/sec_alarm_counter_test.sv
module sec_alarm_counter_test;
    localparam int SW = 8;
    localparam int FW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick, sec_wr, frac_wr, alarm_wr, fail;
    logic [SW-1:0] wdata;
    logic [1:0]    cset, cclr;
    logic [2:0]    fclr;
    logic [SW-1:0] sec, alarm;
    logic [FW-1:0] frac;
    logic [1:0]    ctl;
    logic [2:0]    flags;
    logic          irq;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    sec_alarm_counter #(.SEC_W(SW), .FRAC_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .sec_wr_i(sec_wr),
        .frac_wr_i(frac_wr), .alarm_wr_i(alarm_wr), .wdata_i(wdata),
        .ctl_set_i(cset), .ctl_clr_i(cclr), .flag_clr_i(fclr),
        .fail_stop_i(fail), .sec_o(sec), .frac_o(frac), .alarm_o(alarm),
        .ctl_o(ctl), .flags_o(flags), .irq_o(irq)
    );

    typedef struct packed {
        logic [3:0] req;
        logic sw, fw, aw, fl, tk;
        logic [1:0] cs, cc;
        logic [2:0] fc;
        logic [7:0] wd;
        logic [7:0] e_sec;
        logic [2:0] e_frac;
        logic [2:0] e_flg;
        logic e_irq;
    } vec_t;

    // flags: {alarm, overflow, non-valid}
    localparam vec_t TBL [20] = '{
        '{4'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b01,2'b00,3'b000, 8'h00, 8'd0, 3'd0,3'b001,1'b0}, // R4 tick blocked
        '{4'd4, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'b00,2'b00,3'b000, 8'h05, 8'd5, 3'd0,3'b001,1'b0}, // R4 load no arm
        '{4'd10,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00,2'b00,3'b001, 8'h00, 8'd5, 3'd0,3'b000,1'b0}, // R10 clear nv
        '{4'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b00,2'b00,3'b000, 8'h00, 8'd5, 3'd0,3'b000,1'b0}, // R4 still frozen
        '{4'd7, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'b00,2'b00,3'b000, 8'h10, 8'd16,3'd0,3'b000,1'b0}, // R7 seconds load
        '{4'd2, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b00,2'b00,3'b000, 8'h00, 8'd16,3'd1,3'b000,1'b0}, // R2
        '{4'd7, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'b00,2'b00,3'b000, 8'hF6, 8'd16,3'd6,3'b000,1'b0}, // R7 fraction load
        '{4'd8, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'b00,2'b00,3'b000, 8'd17, 8'd16,3'd6,3'b000,1'b0}, // R8 alarm load
        '{4'd2, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b00,2'b00,3'b000, 8'h00, 8'd16,3'd7,3'b000,1'b0}, // R2
        '{4'd8, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b00,2'b00,3'b000, 8'h00, 8'd17,3'd0,3'b100,1'b0}, // R8 match
        '{4'd9, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b10,2'b00,3'b000, 8'h00, 8'd17,3'd0,3'b100,1'b1}, // R9
        '{4'd10,1'b0,1'b0,1'b0,1'b0,1'b1, 2'b00,2'b00,3'b100, 8'h00, 8'd17,3'd1,3'b000,1'b0}, // R10
        '{4'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00,2'b01,3'b000, 8'h00, 8'd17,3'd1,3'b000,1'b0}, // R3
        '{4'd3, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b00,2'b00,3'b000, 8'h00, 8'd17,3'd1,3'b000,1'b0}, // R3
        '{4'd3, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b01,2'b00,3'b000, 8'h00, 8'd17,3'd1,3'b000,1'b0}, // R3
        '{4'd2, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b00,2'b00,3'b000, 8'h00, 8'd17,3'd2,3'b000,1'b0}, // R2
        '{4'd6, 1'b0,1'b0,1'b0,1'b1,1'b1, 2'b00,2'b00,3'b000, 8'h00, 8'd17,3'd2,3'b000,1'b0}, // R6
        '{4'd6, 1'b1,1'b0,1'b0,1'b1,1'b0, 2'b00,2'b00,3'b000, 8'h40, 8'd17,3'd2,3'b000,1'b0}, // R6
        '{4'd6, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b00,2'b00,3'b000, 8'h00, 8'd17,3'd3,3'b000,1'b0}, // R6
        '{4'd7, 1'b1,1'b0,1'b0,1'b0,1'b1, 2'b00,2'b00,3'b000, 8'h20, 8'd32,3'd3,3'b000,1'b0}  // R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        tick = 0; sec_wr = 0; frac_wr = 0; alarm_wr = 0; fail = 0;
        wdata = '0; cset = '0; cclr = '0; fclr = '0;
    endtask

    task automatic step(input vec_t v);
        tick = v.tk; sec_wr = v.sw; frac_wr = v.fw; alarm_wr = v.aw; fail = v.fl;
        wdata = v.wd; cset = v.cs; cclr = v.cc; fclr = v.fc;
        @(posedge clk); #1;
        idle();
        @(negedge clk);
    endtask

    function automatic vec_t op(input logic sw, fw, aw, tk, input logic [2:0] fc,
                                input logic [1:0] cs, cc, input logic [7:0] wd);
        vec_t v = '0;
        v.sw = sw; v.fw = fw; v.aw = aw; v.tk = tk; v.fc = fc;
        v.cs = cs; v.cc = cc; v.wd = wd;
        return v;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sec", sec, 0);
        chk("R1 frac", frac, 0);
        chk("R1 alarm", alarm, 8'hFF);
        chk("R1 ctl", ctl, 0);
        chk("R1 flags", flags, 3'b001);
        chk("R1 irq", irq, 0);

        for (int i = 0; i < 20; i++) begin
            string t;
            t = $sformatf("R%0d row%0d", TBL[i].req, i);
            step(TBL[i]);
            chk({t, " sec"}, sec, TBL[i].e_sec);
            chk({t, " frac"}, frac, TBL[i].e_frac);
            chk({t, " flags"}, flags, TBL[i].e_flg);
            chk({t, " irq"}, irq, TBL[i].e_irq);
        end

        // R5 overflow: preload all ones, one tick wraps and stops
        step(op(1, 1, 0, 0, 3'b000, 2'b00, 2'b00, 8'hFF));
        chk("R7 both loads sec", sec, 8'hFF);
        chk("R7 both loads frac", frac, 7);
        step(op(0, 0, 0, 1, 3'b000, 2'b00, 2'b00, 8'h00));
        chk("R5 wrap sec", sec, 0);
        chk("R5 wrap frac", frac, 0);
        chk("R5 ovf flag", flags, 3'b010);
        step(op(0, 0, 0, 1, 3'b000, 2'b00, 2'b00, 8'h00));
        chk("R5 stopped", frac, 0);
        step(op(0, 0, 0, 1, 3'b010, 2'b00, 2'b00, 8'h00));
        chk("R5 cleared flag", flags, 3'b000);
        chk("R5 needs load", frac, 0);
        step(op(0, 0, 0, 1, 3'b000, 2'b00, 2'b00, 8'h00));
        chk("R5 still frozen", frac, 0);
        step(op(1, 0, 0, 0, 3'b000, 2'b00, 2'b00, 8'h03));
        step(op(0, 0, 0, 1, 3'b000, 2'b00, 2'b00, 8'h00));
        chk("R5 restart sec", sec, 3);
        chk("R5 restart frac", frac, 1);

        // R10 set beats clear on a flag; R8 match at wrap of fraction
        step(op(1, 1, 1, 0, 3'b000, 2'b00, 2'b00, 8'h37));
        step(op(0, 0, 1, 0, 3'b000, 2'b00, 2'b00, 8'h38));
        step(op(0, 0, 0, 1, 3'b100, 2'b00, 2'b00, 8'h00));
        chk("R8 match sec", sec, 8'h38);
        chk("R10 set wins flag", flags, 3'b100);
        chk("R9 irq on", irq, 1);
        step(op(0, 0, 0, 0, 3'b100, 2'b00, 2'b00, 8'h00));
        chk("R10 flag cleared", flags, 3'b000);
        chk("R9 irq off", irq, 0);

        // R10 control set and clear together
        step(op(0, 0, 0, 0, 3'b000, 2'b10, 2'b10, 8'h00));
        chk("R10 ctl set wins", ctl, 2'b11);

        // R8 all-ones alarm never matches
        step(op(0, 0, 1, 0, 3'b000, 2'b00, 2'b00, 8'hFF));
        step(op(1, 0, 0, 0, 3'b000, 2'b00, 2'b00, 8'hFE));
        step(op(0, 1, 0, 0, 3'b000, 2'b00, 2'b00, 8'h07));
        step(op(0, 0, 0, 1, 3'b000, 2'b00, 2'b00, 8'h00));
        chk("R8 reached ones", sec, 8'hFF);
        chk("R8 no match", flags, 3'b000);
        chk("R9 stays low", irq, 0);

        summary();
    end
endmodule